// File: doc/BRIEF.md
# Fixed-Point Multiply, Round and Overflow Unit

This block multiplies two two's-complement (or, by parameter, unsigned) fixed-point operands that share one format: DW bits in total, of which FRAC are fraction bits, so a raw word r stands for r / 2^FRAC. The product is first formed at full double width without loss. It is then brought back to the operand scale by dropping FRAC fraction bits under a rounding policy fixed at build time. Last, it is fitted into DW bits under an overflow policy also fixed at build time. The result is registered, so it appears one clock after the operands are presented.

When a nonzero constant divisor is set by parameter, the second operand is replaced by the reciprocal round(2^FRAC / k). The unit then divides the first operand by k with no divider hardware. A trap policy turns any overflow into a sticky flag that freezes the output at the clamped value until software-independent logic upstream pulses the clear input.

Top module: `fxp_mul_unit`

## Requirements
- R1: With truncating rounding (RND_TRUNC, code 0), the result equals floor(p / 2^FRAC), where p is the exact product of the two operands.
- R2: With nearest rounding (RND_NEAREST, code 1), the result equals floor((p + 2^(FRAC-1)) / 2^FRAC), so exact halves round toward plus infinity.
- R3: With half-even rounding (RND_EVEN, code 2), a value lying exactly halfway goes to the neighbour whose least significant bit is 0; all other values go to the nearest neighbour.
- R4: With the wrap policy (OVF_WRAP, code 0), the result is the low DW bits of the rounded value. The flag output is 1 for exactly those results whose rounded value lay outside the representable range.
- R5: With the saturate policy (OVF_SAT, code 1), an out-of-range value is replaced by the most positive or most negative DW-bit value of the format, and the flag is 1 for that result.
- R6: With the trap policy (OVF_TRAP, code 2), an overflow loads the clamped value and sets the flag. While the flag is set and clear is low, the flag stays 1 and the result holds, whatever the operands. Clear with a valid operand processes that operand normally; clear alone drops the flag.
- R7: With SIGNED = 0, operands are read as unsigned integers and the representable range is 0 to 2^DW - 1.
- R8: With DIV_K nonzero, the second operand input is ignored and the multiplier is round(2^FRAC / DIV_K). In a 16-bit word with 8 fraction bits and DIV_K = 10, this multiplier is 26, so an input of 2560 gives 260.
- R9: The output valid equals the input valid one clock earlier. The result and the flag change only on a cycle with valid input or, for the flag, on clear.
- R10: Under synchronous reset, result, flag and output valid are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| op_a | input | DW | First operand, raw fixed-point |
| op_b | input | DW | Second operand; ignored when DIV_K is nonzero |
| clr | input | 1 | Clears the overflow flag |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | DW | Scaled, rounded and range-fitted product |
| ovf | output | 1 | Overflow indication (sticky under trap) |

## Verification
A wrong rounding bias or shift shows at the result port on the very next valid cycle. It appears as a one-count error on halfway products, or as a gross error when the shift is misplaced. A wrong range limit shows as a missing or spurious flag and as a non-extreme value where clamping was due, again one cycle after the offending operands. Trap-state faults are the slowest to surface: a lost stickiness or a missed hold shows only on the first later operand presented before a clear. The sweep therefore interleaves clears, idle cycles and every operand pair so that each such window is crossed many times.

// File: rtl/fxp_pkg.sv
package fxp_pkg;
  typedef enum logic [1:0] {
    RND_TRUNC   = 2'd0,
    RND_NEAREST = 2'd1,
    RND_EVEN    = 2'd2
  } rnd_e;

  typedef enum logic [1:0] {
    OVF_WRAP = 2'd0,
    OVF_SAT  = 2'd1,
    OVF_TRAP = 2'd2
  } ovf_e;

  // round(2^frac / k) for a positive constant k
  function automatic longint recip_const(int frac, int k);
    longint num;
    num = longint'(1) <<< (frac + 1);
    return ((num / longint'(k)) + 1) >>> 1;
  endfunction
endpackage

// File: rtl/fxp_round.sv
module fxp_round #(
  parameter int           DW     = 8,
  parameter int           FRAC   = 4,
  parameter bit           SIGNED = 1'b1,
  parameter fxp_pkg::rnd_e RND   = fxp_pkg::RND_TRUNC
) (
  input  logic [DW-1:0]          a_i,
  input  logic [DW-1:0]          b_i,
  output logic signed [2*DW+1:0] q_o
);
  localparam int PW = 2*DW + 2;

  logic signed [DW:0]   a_x, b_x;
  logic signed [PW-1:0] prod, bias, sum;

  generate
    if (SIGNED) begin : g_sext
      assign a_x = {a_i[DW-1], a_i};
      assign b_x = {b_i[DW-1], b_i};
    end else begin : g_zext
      assign a_x = {1'b0, a_i};
      assign b_x = {1'b0, b_i};
    end
  endgenerate

  assign prod = PW'(a_x) * PW'(b_x);

  generate
    if (FRAC == 0 || RND == fxp_pkg::RND_TRUNC) begin : g_trunc
      assign bias = '0;
    end else if (RND == fxp_pkg::RND_NEAREST) begin : g_near
      localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);
      assign bias = HALF;
    end else begin : g_even
      localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);
      assign bias = HALF - PW'(1) + PW'({1'b0, prod[FRAC]});
    end
  endgenerate

  assign sum = prod + bias;
  assign q_o = sum >>> FRAC;

  // rounding may only lift the truncated value by one step (R2, R3)
  logic signed [PW-1:0] q_floor, q_step;
  assign q_floor = prod >>> FRAC;
  assign q_step  = q_o - q_floor;
  always_comb begin
    if (!$isunknown(prod)) begin
      assert_round_step_R2: assert (q_step == '0 || q_step == PW'(1))
        else $error("rounding moved result by more than one step");
    end
  end
endmodule

// File: rtl/fxp_limit.sv
module fxp_limit #(
  parameter int            DW     = 8,
  parameter bit            SIGNED = 1'b1,
  parameter fxp_pkg::ovf_e OVF    = fxp_pkg::OVF_WRAP
) (
  input  logic signed [2*DW+1:0] q_i,
  output logic [DW-1:0]          val_o,
  output logic                   over_o
);
  localparam int PW = 2*DW + 2;
  localparam logic signed [PW-1:0] MAXV = SIGNED ? ((PW'(1) <<< (DW-1)) - PW'(1))
                                                 : ((PW'(1) <<< DW) - PW'(1));
  localparam logic signed [PW-1:0] MINV = SIGNED ? -(PW'(1) <<< (DW-1)) : '0;

  logic hi, lo;
  logic [DW-1:0] clamped;

  assign hi     = q_i > MAXV;
  assign lo     = q_i < MINV;
  assign over_o = hi | lo;

  always_comb begin
    if (hi)      clamped = MAXV[DW-1:0];
    else if (lo) clamped = MINV[DW-1:0];
    else         clamped = q_i[DW-1:0];
  end

  generate
    if (OVF == fxp_pkg::OVF_WRAP) begin : g_wrap
      assign val_o = q_i[DW-1:0];
    end else begin : g_clamp
      assign val_o = clamped;
    end
  endgenerate

  always_comb begin
    if (!$isunknown(q_i) && over_o && OVF != fxp_pkg::OVF_WRAP) begin
      assert_clamp_extreme_R5: assert (val_o == MAXV[DW-1:0] || val_o == MINV[DW-1:0])
        else $error("out-of-range value not clamped to an extreme");
    end
  end
endmodule

// File: rtl/fxp_mul_unit.sv
module fxp_mul_unit #(
  parameter int            DW     = 8,
  parameter int            FRAC   = 4,
  parameter bit            SIGNED = 1'b1,
  parameter fxp_pkg::rnd_e RND    = fxp_pkg::RND_TRUNC,
  parameter fxp_pkg::ovf_e OVF    = fxp_pkg::OVF_WRAP,
  parameter int            DIV_K  = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          clr,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          ovf
);
  localparam int PW      = 2*DW + 2;
  localparam bit IS_TRAP = (OVF == fxp_pkg::OVF_TRAP);

  logic [DW-1:0]          b_eff;
  logic signed [PW-1:0]   q_round;
  logic [DW-1:0]          lim_val;
  logic                   lim_over;

  generate
    if (DIV_K != 0) begin : g_recip
      localparam longint RC = fxp_pkg::recip_const(FRAC, DIV_K);
      assign b_eff = RC[DW-1:0];
    end else begin : g_direct
      assign b_eff = op_b;
    end
  endgenerate

  fxp_round #(.DW(DW), .FRAC(FRAC), .SIGNED(SIGNED), .RND(RND)) u_round (
    .a_i (op_a),
    .b_i (b_eff),
    .q_o (q_round)
  );

  fxp_limit #(.DW(DW), .SIGNED(SIGNED), .OVF(OVF)) u_limit (
    .q_i    (q_round),
    .val_o  (lim_val),
    .over_o (lim_over)
  );

  logic frozen;
  assign frozen = IS_TRAP && ovf && !clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (!frozen) begin
          result <= lim_val;
          ovf    <= lim_over;
        end
      end else if (clr) begin
        ovf <= 1'b0;
      end
    end
  end

  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));
  assert_trap_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (IS_TRAP && ovf && !clr) |=> (ovf && $stable(result)));
  assert_clear_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (clr && !in_valid) |=> !ovf);
endmodule

// File: tb/fxp_mul_unit_bench.sv
module fxp_mul_unit_bench;
  logic clk = 1'b0;
  always #2ns clk = ~clk;

  logic        rst, in_valid, clr;
  logic [7:0]  op_a, op_b;
  logic [15:0] a16, b16;

  logic [7:0]  r0, r1, r2, r3;
  logic [15:0] r4;
  logic [4:0]  ov, vo;

  int nchecks = 0;
  int errors  = 0;
  bit done    = 1'b0;

  longint exp_res [5];
  bit     exp_ovf [5];

  // R1 R4: truncate, wrap
  fxp_mul_unit #(.DW(8), .FRAC(4), .SIGNED(1'b1), .RND(fxp_pkg::RND_TRUNC),
                 .OVF(fxp_pkg::OVF_WRAP)) u_fxp_mul_unit_wrap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b), .clr(clr),
    .out_valid(vo[0]), .result(r0), .ovf(ov[0]));
  // R2 R5: nearest, saturate
  fxp_mul_unit #(.DW(8), .FRAC(4), .SIGNED(1'b1), .RND(fxp_pkg::RND_NEAREST),
                 .OVF(fxp_pkg::OVF_SAT)) u_fxp_mul_unit_sat (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b), .clr(clr),
    .out_valid(vo[1]), .result(r1), .ovf(ov[1]));
  // R3 R6: half-even, trap
  fxp_mul_unit #(.DW(8), .FRAC(4), .SIGNED(1'b1), .RND(fxp_pkg::RND_EVEN),
                 .OVF(fxp_pkg::OVF_TRAP)) u_fxp_mul_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b), .clr(clr),
    .out_valid(vo[2]), .result(r2), .ovf(ov[2]));
  // R7: unsigned, half-even, saturate
  fxp_mul_unit #(.DW(8), .FRAC(4), .SIGNED(1'b0), .RND(fxp_pkg::RND_EVEN),
                 .OVF(fxp_pkg::OVF_SAT)) u_fxp_mul_unit_uns (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b), .clr(clr),
    .out_valid(vo[3]), .result(r3), .ovf(ov[3]));
  // R8: divide by 10 in a 16-bit word with 8 fraction bits
  fxp_mul_unit #(.DW(16), .FRAC(8), .SIGNED(1'b1), .RND(fxp_pkg::RND_TRUNC),
                 .OVF(fxp_pkg::OVF_WRAP), .DIV_K(10)) u_fxp_mul_unit_div (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(a16), .op_b(b16), .clr(clr),
    .out_valid(vo[4]), .result(r4), .ovf(ov[4]));

  task automatic chk(string req, longint act, longint exp);
    nchecks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint scale(longint p, int frac, int rnd);
    longint half;
    if (frac == 0) return p;
    half = longint'(1) <<< (frac - 1);
    case (rnd)
      0:       return p >>> frac;
      1:       return (p + half) >>> frac;
      default: return (p + half - 1 + ((p >>> frac) & 1)) >>> frac;
    endcase
  endfunction

  task automatic model(int idx, longint a, longint b, int dw, int frac, bit sgn,
                       int rnd, int om);
    longint q, maxv, minv, mask, val;
    bit over;
    mask = (longint'(1) <<< dw) - 1;
    maxv = sgn ? (longint'(1) <<< (dw-1)) - 1 : mask;
    minv = sgn ? -(longint'(1) <<< (dw-1)) : 0;
    q    = scale(a * b, frac, rnd);
    over = (q > maxv) || (q < minv);
    if (om == 0)       val = q & mask;
    else if (q > maxv) val = maxv & mask;
    else if (q < minv) val = minv & mask;
    else               val = q & mask;
    if (in_valid) begin
      if (!(om == 2 && exp_ovf[idx] && !clr)) begin
        exp_res[idx] = val;
        exp_ovf[idx] = over;
      end
    end else if (clr) begin
      exp_ovf[idx] = 1'b0;
    end
  endtask

  function automatic longint s8(logic [7:0] x);
    return longint'($signed(x));
  endfunction

  task automatic compare_all();
    chk("R1/R4 result", longint'(r0), exp_res[0]);
    chk("R4 flag",      longint'(ov[0]), longint'(exp_ovf[0]));
    chk("R2/R5 result", longint'(r1), exp_res[1]);
    chk("R5 flag",      longint'(ov[1]), longint'(exp_ovf[1]));
    chk("R3/R6 result", longint'(r2), exp_res[2]);
    chk("R6 flag",      longint'(ov[2]), longint'(exp_ovf[2]));
    chk("R7 result",    longint'(r3), exp_res[3]);
    chk("R7 flag",      longint'(ov[3]), longint'(exp_ovf[3]));
    chk("R8 result",    longint'(r4), exp_res[4]);
    chk("R9 out_valid", longint'(vo), in_valid ? 31 : 0);
  endtask

  task automatic drive(logic [15:0] v, bit vld, bit c);
    op_a = v[7:0]; op_b = v[15:8];
    a16 = v; b16 = ~v;          // b16 must have no effect (R8)
    in_valid = vld; clr = c;
    model(0, s8(op_a), s8(op_b), 8, 4, 1'b1, 0, 0);
    model(1, s8(op_a), s8(op_b), 8, 4, 1'b1, 1, 1);
    model(2, s8(op_a), s8(op_b), 8, 4, 1'b1, 2, 2);
    model(3, longint'(op_a), longint'(op_b), 8, 4, 1'b0, 2, 1);
    model(4, longint'($signed(a16)), 26, 16, 8, 1'b1, 0, 0);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; clr = 1'b0;
    op_a = '0; op_b = '0; a16 = '0; b16 = '0;
    for (int k = 0; k < 5; k++) begin exp_res[k] = 0; exp_ovf[k] = 1'b0; end
    repeat (3) @(negedge clk);
    chk("R10 reset result", longint'({r0, r1, r2, r3, r4}), 0);
    chk("R10 reset flag",   longint'(ov), 0);
    chk("R10 reset valid",  longint'(vo), 0);
    rst = 1'b0;
    for (int i = 0; i < 65536; i++) begin
      drive(16'(i), (i % 7) != 3, (i % 13) == 5);
    end
    // trap hold: overflow then a small operand without clear (R6)
    drive(16'h7f7f, 1'b1, 1'b1);   // 127*127/16 overflows
    drive(16'h0101, 1'b1, 1'b0);
    chk("R6 held at max", longint'(r2), 127);
    drive(16'h0101, 1'b1, 1'b1);   // clear with valid: processed normally
    chk("R6 after clear", longint'(r2), 0);
    // exact half: 3*8/16 = 1.5 -> even gives 2, nearest gives 2; 1*8/16=0.5 -> even 0, nearest 1
    drive(16'h0801, 1'b1, 1'b1);
    chk("R3 half to even", longint'(r2), 0);
    chk("R2 half up", longint'(r1), 1);
    // 10.0 divided by 10 in Q8.8 (R8)
    drive(16'd2560, 1'b1, 1'b0);
    chk("R8 divide 2560", longint'(r4), 260);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, nchecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; nchecks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, nchecks);
      $finish;
    end
  end
endmodule